// File: doc/BRIEF.md
# PWM Clip Detector with Shared Status Pin

This block watches the pulse-width-modulated output bit of every amplifier channel and flags a channel as clipping when its duty cycle sits at 0 % or 100 % for a whole modulation period. A period is the span between two strobes on the period input. The flag stays up for as long as every later period is also stuck, and it drops at the first period in which the bit changes at least once.

One active-low status pin is shared by several reporting sources. A 2-bit source field picks what the pin carries: the OR of all channel clip flags, the overtemperature-warning input, both of those combined, or the OR of the tweeter-detect event inputs. The tweeter source only works while the diagnostic-mode flag is set. The pin is driven from a flip-flop so that it cannot glitch. The reset input is asserted asynchronously and released synchronously inside the block.

Top module: `clip_status_mux`

## Requirements
- R1: While reset is applied, and afterwards until a source reports, `status_n_o` is high (deasserted).
- R2: The first `period_stb_i` after reset release only opens observation: no channel is flagged as clipping by the period that this strobe closes.
- R3: A channel is flagged at a closing strobe when its PWM bit held one value, high or low, on every cycle from the cycle after the previous strobe through the strobe cycle itself.
- R4: A change of the PWM bit on any cycle of a period, including the strobe cycle and the first cycle after the previous strobe, clears that channel's flag at the closing strobe. A change between the strobe cycle and the cycle after it belongs to the new period only.
- R5: A flag stays set across consecutive stuck periods and changes only at strobes. It releases at the first strobe that closes a period containing a change.
- R6: Source field 2'b00: the pin is low exactly when at least one channel is flagged.
- R7: Source field 2'b01: the pin is the inverse of the overtemperature-warning input, and clip flags have no effect.
- R8: Source field 2'b10: the pin is low when any channel is flagged or the warning input is high.
- R9: Source field 2'b11: with the diagnostic flag set, the pin is low when any tweeter-detect event input is high. With the diagnostic flag clear, the pin stays high.
- R10: The pin is registered. It follows a change of the source inputs one clock edge after they are sampled. It follows a change in the clip flags one edge after the edge that samples the closing strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_i | input | NUM_CH | PWM output bit of each channel |
| period_stb_i | input | 1 | High on the last cycle of each PWM period |
| otw_i | input | 1 | Overtemperature warning, active high |
| tw_evt_i | input | NUM_CH | Tweeter-detect event per channel, active high |
| diag_mode_i | input | 1 | Diagnostic mode enable |
| mode_sel_i | input | 2 | Status source: 00 clip, 01 warning, 10 both, 11 tweeter |
| status_n_o | output | 1 | Active-low status pin |

## Verification
The hardest situations to reach are bit changes that fall exactly on a period edge. One case is a change on the strobe cycle, which must count for the closing period. The other is a change on the very first cycle after it, which must not count for that period. The stimulus rotates the single change in each period through every cycle position. It combines this with all sixteen stuck/active channel masks under every source, diagnostic and warning setting. It also probes the pin one cycle after each strobe edge to pin down the latency.

// File: rtl/clip_status_pkg.sv
package clip_status_pkg;

  // Source selection for the shared status pin
  typedef enum logic [1:0] {
    SRC_CLIP  = 2'b00,
    SRC_THERM = 2'b01,
    SRC_BOTH  = 2'b10,
    SRC_TWEET = 2'b11
  } stat_src_e;

endpackage

// File: rtl/clip_rst_sync.sv
module clip_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/clip_chan_monitor.sv
module clip_chan_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_i,
  input  logic stb_i,
  output logic clip_o
);

  logic prev_q, prev_d;
  logic seen_q, seen_d;
  logic armed_q, armed_d;
  logic clip_q, clip_d;
  logic edge_now;
  logic period_active;

  // Next-state logic
  always_comb begin
    edge_now      = pwm_i ^ prev_q;
    period_active = seen_q | edge_now;
    prev_d        = pwm_i;
    seen_d        = period_active;
    armed_d       = armed_q;
    clip_d        = clip_q;
    if (stb_i) begin
      seen_d  = 1'b0;
      armed_d = 1'b1;
      if (armed_q) clip_d = ~period_active;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      seen_q  <= 1'b0;
      armed_q <= 1'b0;
      clip_q  <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      seen_q  <= seen_d;
      armed_q <= armed_d;
      clip_q  <= clip_d;
    end
  end

  assign clip_o = clip_q;

endmodule

// File: rtl/clip_src_select.sv
module clip_src_select
  import clip_status_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      any_clip_i,
  input  logic      otw_i,
  input  logic      any_tw_i,
  input  logic      diag_i,
  input  stat_src_e src_i,
  output logic      status_n_o
);

  logic report;
  logic status_n_d, status_n_q;

  always_comb begin
    case (src_i)
      SRC_CLIP:  report = any_clip_i;
      SRC_THERM: report = otw_i;
      SRC_BOTH:  report = any_clip_i | otw_i;
      SRC_TWEET: report = diag_i & any_tw_i;
      default:   report = 1'b0;
    endcase
    status_n_d = ~report;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_n_q <= 1'b1;
    else        status_n_q <= status_n_d;
  end

  assign status_n_o = status_n_q;

endmodule

// File: rtl/clip_status_mux.sv
module clip_status_mux
  import clip_status_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] pwm_i,
  input  logic              period_stb_i,
  input  logic              otw_i,
  input  logic [NUM_CH-1:0] tw_evt_i,
  input  logic              diag_mode_i,
  input  logic [1:0]        mode_sel_i,
  output logic              status_n_o
);

  logic              rst_sync_n;
  logic [NUM_CH-1:0] clip_vec;
  logic              any_clip;
  logic              any_tw;
  stat_src_e         src_sel;

  clip_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    clip_chan_monitor u_mon (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .pwm_i  (pwm_i[c]),
      .stb_i  (period_stb_i),
      .clip_o (clip_vec[c])
    );
  end

  always_comb begin
    any_clip = |clip_vec;
    any_tw   = |tw_evt_i;
    src_sel  = stat_src_e'(mode_sel_i);
  end

  clip_src_select u_sel (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .any_clip_i (any_clip),
    .otw_i      (otw_i),
    .any_tw_i   (any_tw),
    .diag_i     (diag_mode_i),
    .src_i      (src_sel),
    .status_n_o (status_n_o)
  );

endmodule

// File: rtl/clip_status_chk.sv
module clip_status_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              period_stb,
  input logic [1:0]        mode,
  input logic              diag,
  input logic              otw,
  input logic [NUM_CH-1:0] tw_evt,
  input logic [NUM_CH-1:0] clip_vec,
  input logic              status_n
);

  logic [1:0] stb_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          stb_cnt <= 2'd0;
    else if (period_stb && stb_cnt != 2'd2) stb_cnt <= stb_cnt + 2'd1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> status_n);

  assert_arming_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_cnt < 2'd2) |-> (clip_vec == '0));

  assert_flag_only_at_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(period_stb)) |-> $stable(clip_vec));

  assert_clip_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode) == 2'b00) |-> (status_n == !(|$past(clip_vec))));

  assert_therm_route_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode) == 2'b01) |-> (status_n == !$past(otw)));

  assert_both_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode) == 2'b10) |-> (status_n == !((|$past(clip_vec)) || $past(otw))));

  assert_tweet_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode) == 2'b11) |-> (status_n == !($past(diag) && (|$past(tw_evt)))));

endmodule

bind clip_status_mux clip_status_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .period_stb (period_stb_i),
  .mode       (mode_sel_i),
  .diag       (diag_mode_i),
  .otw        (otw_i),
  .tw_evt     (tw_evt_i),
  .clip_vec   (clip_vec),
  .status_n   (status_n_o)
);

// File: tb/clip_status_mux_tb.sv
module clip_status_mux_tb;

  localparam int NCH = 4;
  localparam int PER = 6;

  logic           clk;
  logic           rst_n;
  logic [NCH-1:0] pwm;
  logic           stb;
  logic           otw;
  logic [NCH-1:0] tw;
  logic           diag;
  logic [1:0]     mode;
  logic           status_n;

  int nvec = 0;
  int nbad = 0;
  bit done = 0;

  logic [NCH-1:0] lvl;
  logic [NCH-1:0] exp_clip;
  logic [NCH-1:0] old_clip;
  bit             armed;

  clip_status_mux #(.NUM_CH(NCH)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwm_i        (pwm),
    .period_stb_i (stb),
    .otw_i        (otw),
    .tw_evt_i     (tw),
    .diag_mode_i  (diag),
    .mode_sel_i   (mode),
    .status_n_o   (status_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic exp_pin(input logic [NCH-1:0] cv);
    logic r;
    case (mode)
      2'b00:   r = |cv;
      2'b01:   r = otw;
      2'b10:   r = (|cv) | otw;
      default: r = diag & (|tw);
    endcase
    return ~r;
  endfunction

  function automatic string mode_tag();
    case (mode)
      2'b00:   return "R6";
      2'b01:   return "R7";
      2'b10:   return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input logic expv, input string tag);
    nvec++;
    if (status_n !== expv) begin
      nbad++;
      $display("FAIL %s: status_n=%b expected %b (mode=%b diag=%b otw=%b) t=%0t",
               tag, status_n, expv, mode, diag, otw, $time);
    end
  endtask

  // One PWM period; channels in hold_mask keep their level (R3),
  // the others change once at cycle tpos (R4).
  task automatic run_period(input logic [NCH-1:0] hold_mask, input int tpos, input string tag);
    string t;
    t = (tag == "") ? mode_tag() : tag;
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      if (i == 0)       chk(exp_pin(old_clip), "R10");
      if (i == 1)       chk(exp_pin(exp_clip), t);
      if (i == PER - 1) chk(exp_pin(exp_clip), t);
      for (int c = 0; c < NCH; c++)
        if (!hold_mask[c] && i == tpos) lvl[c] = ~lvl[c];
      pwm = lvl;
      stb = (i == PER - 1);
    end
    old_clip = exp_clip;
    if (armed) exp_clip = hold_mask;
    armed = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pwm = '0; stb = 1'b0; otw = 1'b0; tw = '0; diag = 1'b0; mode = 2'b00;
    lvl = '0; exp_clip = '0; old_clip = '0; armed = 1'b0;
    repeat (4) @(negedge clk);
    chk(1'b1, "R1");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(1'b1, "R1");

    // R2: arming period with all channels stuck must not flag
    run_period('1, 0, "R2");
    run_period('1, 0, "R2");
    // R3: second full stuck period flags everything (low level)
    run_period('1, 0, "R3");
    // R5: stays flagged; ch0 changes on the strobe cycle (R4)
    run_period('1, 0, "R5");
    run_period(4'b1110, PER - 1, "R5");
    // R4: a change on the first cycle after the strobe does not clear the previous period
    run_period('1, 0, "R4");
    run_period('0, 0, "R4");
    // R5: release after an active period
    run_period('0, 2, "R5");
    run_period('0, 3, "R5");

    // R10: warning source follows the input one edge later
    mode = 2'b01; otw = 1'b0;
    run_period('0, 1, "R10");
    @(negedge clk);
    stb = 1'b0;
    otw = 1'b1;
    chk(1'b1, "R10");
    @(negedge clk);
    chk(1'b0, "R10");
    otw = 1'b0;
    @(negedge clk);
    chk(1'b1, "R10");
    old_clip = exp_clip;

    // Sweep of sources, diag, warning, tweeter events, masks and change positions
    for (int m = 0; m < 4; m++)
      for (int d = 0; d < 2; d++)
        for (int o = 0; o < 2; o++)
          for (int t = 0; t < 2; t++) begin
            mode = 2'(m);
            diag = d[0];
            otw  = o[0];
            tw   = (t != 0) ? NCH'(1 << ((m + o) % NCH)) : '0;
            for (int k = 0; k < 16; k++)
              run_period(NCH'(k), (k + m + o) % PER, "");
          end

    @(negedge clk);
    stb = 1'b0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule